// File: doc/BRIEF.md
# DMA Controller Host Register Interface

This block is the processor-side register file of a four-channel DMA controller. Software reaches it through a byte-wide I/O port addressed by a 4-bit offset. Each channel holds a 16-bit memory address and a 16-bit transfer count. Both are accessed one byte at a time through a single shared byte pointer: the first access reaches the low byte and the second reaches the high byte. Software can force the pointer back to the low byte.

The upper half of the offset space holds the global registers: command, software request, per-channel and all-channel masks, and per-channel mode bytes. A combined status byte reports pending requests and terminal counts. Three offsets are pure action strobes. They clear the byte pointer, perform a master clear, or unmask every channel, whatever data is written.

The transfer engine reads the register contents from flat output buses. It returns terminal-count events, hardware request levels and the byte held during a memory-to-memory move. Accesses are sampled on the rising clock edge while `cs_i` is high. Read data is combinational from the current state. Read side effects, such as advancing the pointer or clearing status, take effect at the edge that ends the access.

Top module: `dma_host_regs`

## Requirements
- R1: After reset all addresses, counts, mode bytes and the command byte are zero, every channel mask is set, software requests and terminal-count flags are clear, and the byte pointer selects the low byte.
- R2: Offsets 0..7 reach channel `offs[2:1]`: even offsets reach the address and odd offsets reach the count. A single byte pointer shared by all eight selects the low byte (pointer 0) or the high byte (pointer 1). Every read or write at these offsets flips the pointer.
- R3: A write to offset 0xC returns the byte pointer to the low byte, whatever the data.
- R4: A write to offset 0xD is a master clear. It sets all masks and clears the command, software requests, terminal-count flags, the temporary byte and the byte pointer. Addresses, counts and mode bytes keep their values.
- R5: A write to offset 0xE clears every mask. A write to offset 0xF loads mask bit n from data bit n.
- R6: A write to offset 0xA selects a channel with data bits 1:0 and sets (bit 2 = 1) or clears (bit 2 = 0) that channel's mask. The other masks stay unchanged.
- R7: A write to offset 0x9 selects a channel with bits 1:0 and sets or clears its software request with bit 2. A terminal-count event on a channel clears its software request, even in the same cycle as a request write.
- R8: A write to offset 0x8 loads the command byte. A write to offset 0xB stores the whole data byte as the mode of the channel selected by data bits 1:0.
- R9: A read at offset 0x8 returns bits 7:4 = hardware request OR software request, and bits 3:0 = sticky terminal-count flags. That read clears the flags at its closing edge, but an event arriving in the same cycle stays recorded.
- R10: A read at offset 0xD returns the temporary byte last loaded by the transfer engine. Reads at 0x9-0xC, 0xE and 0xF return zero. When no read is active, rdata_o is zero. If read and write are both asserted, the access is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Port select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| offs_i | input | 4 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| dreq_i | input | 4 | Hardware request levels per channel |
| tc_set_i | input | 4 | Terminal-count event pulses per channel |
| temp_we_i | input | 1 | Load strobe for the temporary byte |
| temp_d_i | input | 8 | Temporary byte from the transfer engine |
| cmd_o | output | 8 | Command byte |
| mode_o | output | 32 | Mode bytes, channel n in bits 8n+7:8n |
| mask_o | output | 4 | Channel masks, 1 = masked |
| sw_req_o | output | 4 | Software requests |
| addr_o | output | 64 | Addresses, channel n in bits 16n+15:16n |
| count_o | output | 64 | Counts, channel n in bits 16n+15:16n |

## Verification
A wrong byte pointer stays hidden until the next access at offsets 0..7. At that access it puts every later byte in the wrong half of a register, so it appears on addr_o/count_o one cycle later and on the next readback. Mask, request and command errors appear on their output ports in the cycle after the offending write. A terminal-count flag that is lost or cleared too early appears only at the next status read, so the bench reads status right after each event and right after each clearing read, including a read that coincides with an event.

// File: rtl/dma_host_pkg.sv
package dma_host_pkg;
  localparam logic [3:0] OFF_CMD    = 4'h8;
  localparam logic [3:0] OFF_REQ    = 4'h9;
  localparam logic [3:0] OFF_SMASK  = 4'hA;
  localparam logic [3:0] OFF_MODE   = 4'hB;
  localparam logic [3:0] OFF_PTRCLR = 4'hC;
  localparam logic [3:0] OFF_MCLR   = 4'hD;
  localparam logic [3:0] OFF_UNMASK = 4'hE;
  localparam logic [3:0] OFF_AMASK  = 4'hF;

  function automatic logic is_chan_off(input logic [3:0] offs);
    return !offs[3];
  endfunction
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tog_i,
  output logic hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_o <= 1'b0;
    else if (clr_i) hi_o <= 1'b0;
    else if (tog_i) hi_o <= !hi_o;
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_we_i,
  input  logic          cnt_we_i,
  input  logic          mode_we_i,
  input  logic          hi_i,
  input  logic [DW-1:0] wdata_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] cnt_o,
  output logic [DW-1:0] mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      cnt_o  <= '0;
      mode_o <= '0;
    end else begin
      if (addr_we_i) begin
        if (hi_i) addr_o[AW-1:DW] <= wdata_i;
        else      addr_o[DW-1:0]  <= wdata_i;
      end
      if (cnt_we_i) begin
        if (hi_i) cnt_o[AW-1:DW] <= wdata_i;
        else      cnt_o[DW-1:0]  <= wdata_i;
      end
      if (mode_we_i) mode_o <= wdata_i;
    end
  end
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs #(
  parameter int CH_N = 4,
  parameter int DW   = 8,
  localparam int SW  = $clog2(CH_N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_we_i,
  input  logic            req_we_i,
  input  logic            smask_we_i,
  input  logic            unmask_i,
  input  logic            amask_we_i,
  input  logic            mclr_i,
  input  logic            stat_rd_i,
  input  logic [CH_N-1:0] tc_set_i,
  input  logic            temp_we_i,
  input  logic [DW-1:0]   temp_d_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   cmd_o,
  output logic [CH_N-1:0] mask_o,
  output logic [CH_N-1:0] req_o,
  output logic [CH_N-1:0] tc_o,
  output logic [DW-1:0]   temp_o
);
  logic [SW-1:0]   sel;
  logic [CH_N-1:0] mask_n, req_n, tc_n;

  assign sel = wdata_i[SW-1:0];

  always_comb begin
    mask_n = mask_o;
    if (unmask_i)        mask_n = '0;
    else if (amask_we_i) mask_n = wdata_i[CH_N-1:0];
    else if (smask_we_i) mask_n[sel] = wdata_i[2];

    req_n = req_o;
    if (req_we_i) req_n[sel] = wdata_i[2];
    req_n = req_n & ~tc_set_i;

    tc_n = (stat_rd_i ? '0 : tc_o) | tc_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o  <= '0;
      mask_o <= '1;
      req_o  <= '0;
      tc_o   <= '0;
      temp_o <= '0;
    end else if (mclr_i) begin
      cmd_o  <= '0;
      mask_o <= '1;
      req_o  <= '0;
      tc_o   <= '0;
      temp_o <= '0;
    end else begin
      if (cmd_we_i) cmd_o <= wdata_i;
      mask_o <= mask_n;
      req_o  <= req_n;
      tc_o   <= tc_n;
      if (temp_we_i) temp_o <= temp_d_i;
    end
  end
endmodule

// File: rtl/dma_host_regs.sv
module dma_host_regs
  import dma_host_pkg::*;
#(
  parameter int CH_N = 4,
  parameter int DW   = 8,
  localparam int AW  = 2 * DW,
  localparam int SW  = $clog2(CH_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [3:0]       offs_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [CH_N-1:0]  dreq_i,
  input  logic [CH_N-1:0]  tc_set_i,
  input  logic             temp_we_i,
  input  logic [DW-1:0]    temp_d_i,
  output logic [DW-1:0]    cmd_o,
  output logic [CH_N*DW-1:0] mode_o,
  output logic [CH_N-1:0]  mask_o,
  output logic [CH_N-1:0]  sw_req_o,
  output logic [CH_N*AW-1:0] addr_o,
  output logic [CH_N*AW-1:0] count_o
);
  logic            wr_act, rd_act, chan_acc, ptr_hi;
  logic [SW-1:0]   ch_sel;
  logic [CH_N-1:0] stat_tc;
  logic [DW-1:0]   temp_q;
  logic [AW-1:0]   addr_w [CH_N];
  logic [AW-1:0]   cnt_w  [CH_N];
  logic [DW-1:0]   mode_w [CH_N];
  logic [AW-1:0]   word;

  assign wr_act   = cs_i && wr_i;
  assign rd_act   = cs_i && rd_i && !wr_i;
  assign chan_acc = (wr_act || rd_act) && is_chan_off(offs_i);
  assign ch_sel   = offs_i[SW:1];

  dma_byte_ptr u_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (wr_act && (offs_i == OFF_PTRCLR || offs_i == OFF_MCLR)),
    .tog_i (chan_acc),
    .hi_o  (ptr_hi)
  );

  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    dma_chan_regs #(.DW(DW)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .addr_we_i(wr_act && is_chan_off(offs_i) && ch_sel == SW'(i) && !offs_i[0]),
      .cnt_we_i (wr_act && is_chan_off(offs_i) && ch_sel == SW'(i) && offs_i[0]),
      .mode_we_i(wr_act && offs_i == OFF_MODE && wdata_i[SW-1:0] == SW'(i)),
      .hi_i     (ptr_hi),
      .wdata_i  (wdata_i),
      .addr_o   (addr_w[i]),
      .cnt_o    (cnt_w[i]),
      .mode_o   (mode_w[i])
    );
    assign addr_o[i*AW +: AW]  = addr_w[i];
    assign count_o[i*AW +: AW] = cnt_w[i];
    assign mode_o[i*DW +: DW]  = mode_w[i];
  end

  dma_ctrl_regs #(.CH_N(CH_N), .DW(DW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_we_i  (wr_act && offs_i == OFF_CMD),
    .req_we_i  (wr_act && offs_i == OFF_REQ),
    .smask_we_i(wr_act && offs_i == OFF_SMASK),
    .unmask_i  (wr_act && offs_i == OFF_UNMASK),
    .amask_we_i(wr_act && offs_i == OFF_AMASK),
    .mclr_i    (wr_act && offs_i == OFF_MCLR),
    .stat_rd_i (rd_act && offs_i == OFF_CMD),
    .tc_set_i  (tc_set_i),
    .temp_we_i (temp_we_i),
    .temp_d_i  (temp_d_i),
    .wdata_i   (wdata_i),
    .cmd_o     (cmd_o),
    .mask_o    (mask_o),
    .req_o     (sw_req_o),
    .tc_o      (stat_tc),
    .temp_o    (temp_q)
  );

  // status byte packs two CH_N-bit fields
  always_comb begin
    rdata_o = '0;
    word    = '0;
    if (rd_act) begin
      if (is_chan_off(offs_i)) begin
        word    = offs_i[0] ? cnt_w[ch_sel] : addr_w[ch_sel];
        rdata_o = ptr_hi ? word[AW-1:DW] : word[DW-1:0];
      end else if (offs_i == OFF_CMD) begin
        rdata_o = DW'({dreq_i | sw_req_o, stat_tc});
      end else if (offs_i == OFF_MCLR) begin
        rdata_o = temp_q;
      end
    end
  end
endmodule

// File: rtl/dma_host_regs_chk.sv
module dma_host_regs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic [3:0] offs_i,
  input logic [7:0] wdata_i,
  input logic [3:0] tc_set_i,
  input logic [3:0] mask_o,
  input logic [7:0] cmd_o,
  input logic [3:0] sw_req_o,
  input logic       ptr_hi,
  input logic [3:0] tc_q
);
  p_ptr_toggle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && (wr_i || rd_i) && !offs_i[3]) |=> (ptr_hi != $past(ptr_hi)));

  p_ptr_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i && offs_i == 4'hC) |=> !ptr_hi);

  p_master_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i && offs_i == 4'hD) |=>
      (mask_o == 4'hF && cmd_o == 8'h00 && sw_req_o == 4'h0 && tc_q == 4'h0 && !ptr_hi));

  p_unmask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i && offs_i == 4'hE) |=> (mask_o == 4'h0));

  p_all_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i && offs_i == 4'hF) |=> (mask_o == $past(wdata_i[3:0])));

  p_req_tc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tc_set_i) |=> ((sw_req_o & $past(tc_set_i)) == 4'h0));

  p_cmd_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i && offs_i == 4'h8) |=> (cmd_o == $past(wdata_i)));

  p_stat_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && !wr_i && offs_i == 4'h8) |=> (tc_q == $past(tc_set_i)));
endmodule

bind dma_host_regs dma_host_regs_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_i    (cs_i),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .offs_i  (offs_i),
  .wdata_i (wdata_i),
  .tc_set_i(tc_set_i),
  .mask_o  (mask_o),
  .cmd_o   (cmd_o),
  .sw_req_o(sw_req_o),
  .ptr_hi  (ptr_hi),
  .tc_q    (stat_tc)
);

// File: tb/sim_dma_host_regs.sv
module sim_dma_host_regs;
  logic        clk = 0, rst_n = 0;
  logic        cs = 0, wr_en = 0, rd_en = 0;
  logic [3:0]  offs = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata;
  logic [3:0]  dreq = 0, tc_set = 0;
  logic        temp_we = 0;
  logic [7:0]  temp_d = 0;
  logic [7:0]  cmd;
  logic [31:0] mode;
  logic [3:0]  mask, sw_req;
  logic [63:0] addr, count;

  int n_chk = 0, n_fail = 0;

  logic [15:0] m_addr [4];
  logic [15:0] m_cnt  [4];
  logic [7:0]  m_mode [4];
  logic [7:0]  m_cmd, m_temp;
  logic [3:0]  m_mask, m_req, m_tc;
  int          m_ff;

  always #5 clk = !clk;

  dma_host_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .wr_i(wr_en), .rd_i(rd_en),
    .offs_i(offs), .wdata_i(wdata), .rdata_o(rdata), .dreq_i(dreq),
    .tc_set_i(tc_set), .temp_we_i(temp_we), .temp_d_i(temp_d),
    .cmd_o(cmd), .mode_o(mode), .mask_o(mask), .sw_req_o(sw_req),
    .addr_o(addr), .count_o(count)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < 4; i++) begin m_addr[i] = 0; m_cnt[i] = 0; m_mode[i] = 0; end
    m_cmd = 0; m_temp = 0; m_mask = 4'hF; m_req = 0; m_tc = 0; m_ff = 0;
  endfunction

  function automatic void model_wr(input logic [3:0] o, input logic [7:0] d);
    if (!o[3]) begin
      if (o[0]) m_cnt[o[2:1]][m_ff*8 +: 8] = d;
      else      m_addr[o[2:1]][m_ff*8 +: 8] = d;
      m_ff = 1 - m_ff;
    end
    case (o)
      4'h8: m_cmd = d;
      4'h9: m_req[d[1:0]] = d[2];
      4'hA: m_mask[d[1:0]] = d[2];
      4'hB: m_mode[d[1:0]] = d;
      4'hC: m_ff = 0;
      4'hD: begin m_mask = 4'hF; m_cmd = 0; m_req = 0; m_tc = 0; m_temp = 0; m_ff = 0; end
      4'hE: m_mask = 0;
      4'hF: m_mask = d[3:0];
      default: ;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input logic [3:0] o);
    logic [15:0] w;
    if (!o[3]) begin
      w = o[0] ? m_cnt[o[2:1]] : m_addr[o[2:1]];
      return m_ff ? w[15:8] : w[7:0];
    end
    if (o == 4'h8) return {dreq | m_req, m_tc};
    if (o == 4'hD) return m_temp;
    return 8'h00;
  endfunction

  task automatic wr(input logic [3:0] o, input logic [7:0] d);
    @(negedge clk); cs = 1; wr_en = 1; offs = o; wdata = d;
    @(negedge clk); cs = 0; wr_en = 0;
    model_wr(o, d);
  endtask

  task automatic rd_chk(input logic [3:0] o, input string r);
    logic [7:0] e;
    e = exp_rd(o);
    @(negedge clk); cs = 1; rd_en = 1; offs = o;
    #1 chk(r, rdata, e);
    @(negedge clk); cs = 0; rd_en = 0;
    if (!o[3]) m_ff = 1 - m_ff;
    if (o == 4'h8) m_tc = 0;
  endtask

  task automatic tc_pulse(input logic [3:0] v);
    @(negedge clk); tc_set = v;
    @(negedge clk); tc_set = 0;
    m_tc |= v; m_req &= ~v;
  endtask

  task automatic chk_outs(input string r);
    #1;
    chk({r, " mask"}, mask, m_mask);
    chk({r, " cmd"}, cmd, m_cmd);
    chk({r, " req"}, sw_req, m_req);
    for (int i = 0; i < 4; i++) begin
      chk({r, " addr"}, addr[i*16 +: 16], m_addr[i]);
      chk({r, " count"}, count[i*16 +: 16], m_cnt[i]);
      chk({r, " mode"}, mode[i*8 +: 8], m_mode[i]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [3:0]  o;
    void'($urandom(32'h00C0FFEE));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_outs("R1 reset");
    rd_chk(4'h8, "R1 reset status");
    rd_chk(4'h0, "R1 reset pointer low");

    // R2 random 16-bit loads and readback
    wr(4'hC, 8'h00);
    for (int k = 0; k < 24; k++) begin
      o = {1'b0, 3'($urandom_range(0, 7))};
      v = 16'($urandom);
      wr(o, v[7:0]); wr(o, v[15:8]);
      chk_outs("R2 load");
      rd_chk(o, "R2 read low"); rd_chk(o, "R2 read high");
    end
    // R2 pointer shared across registers
    wr(4'h0, 8'h5A); wr(4'h3, 8'hC3);
    chk_outs("R2 shared pointer");
    rd_chk(4'h6, "R2 read after odd access");
    // R3 pointer clear mid-word
    wr(4'h4, 8'h11); wr(4'hC, 8'hFF); wr(4'h4, 8'h22); wr(4'h4, 8'h33);
    chk_outs("R3 pointer clear");
    rd_chk(4'h2, "R3 pointer low"); wr(4'hC, 8'h00); rd_chk(4'h4, "R3 read low after clear");
    wr(4'hC, 8'h00);

    // R8 command and mode
    for (int k = 0; k < 8; k++) begin
      wr(4'h8, 8'($urandom)); wr(4'hB, 8'($urandom));
      chk_outs("R8 cmd/mode");
    end

    // R5 and R6 masks
    wr(4'hE, 8'hA5); chk_outs("R5 unmask");
    wr(4'hF, 8'h0A); chk_outs("R5 all-mask");
    for (int k = 0; k < 12; k++) begin
      wr(4'hA, 8'($urandom)); chk_outs("R6 single mask");
    end
    wr(4'hF, 8'hF5); chk_outs("R5 all-mask high bits ignored");

    // R7 software requests
    for (int k = 0; k < 10; k++) begin
      wr(4'h9, 8'($urandom)); chk_outs("R7 request");
    end
    wr(4'h9, 8'h06); wr(4'h9, 8'h05);
    tc_pulse(4'h2); chk_outs("R7 tc clears request");
    @(negedge clk); cs = 1; wr_en = 1; offs = 4'h9; wdata = 8'h07; tc_set = 4'h8;
    @(negedge clk); cs = 0; wr_en = 0; tc_set = 0;
    model_wr(4'h9, 8'h07); m_tc |= 4'h8; m_req &= ~4'h8;
    chk_outs("R7 tc beats request write");

    // R9 status
    for (int k = 0; k < 8; k++) begin
      dreq = 4'($urandom);
      tc_pulse(4'($urandom));
      rd_chk(4'h8, "R9 status");
      rd_chk(4'h8, "R9 status after clear");
    end
    dreq = 0;
    @(negedge clk); cs = 1; rd_en = 1; offs = 4'h8; tc_set = 4'h1;
    #1 chk("R9 read with event", rdata, exp_rd(4'h8));
    @(negedge clk); cs = 0; rd_en = 0; tc_set = 0;
    m_tc = 4'h1; m_req &= ~4'h1;
    rd_chk(4'h8, "R9 coincident event kept");

    // R10 temp and empty reads
    @(negedge clk); temp_we = 1; temp_d = 8'h9C;
    @(negedge clk); temp_we = 0; m_temp = 8'h9C;
    rd_chk(4'hD, "R10 temp");
    rd_chk(4'h9, "R10 empty 9"); rd_chk(4'hC, "R10 empty C"); rd_chk(4'hF, "R10 empty F");
    #1 chk("R10 idle rdata", rdata, 8'h00);
    @(negedge clk); cs = 1; rd_en = 1; wr_en = 1; offs = 4'h8; wdata = 8'h3C;
    #1 chk("R10 write wins rdata", rdata, 8'h00);
    @(negedge clk); cs = 0; rd_en = 0; wr_en = 0; model_wr(4'h8, 8'h3C);
    chk_outs("R10 write wins");

    // R4 master clear
    wr(4'hE, 8'h00); wr(4'h9, 8'h05); wr(4'h8, 8'h77); tc_pulse(4'h4);
    wr(4'h1, 8'hEE);
    wr(4'hD, 8'h00);
    chk_outs("R4 master clear");
    rd_chk(4'h8, "R4 status cleared");
    rd_chk(4'hD, "R4 temp cleared");
    wr(4'h7, 8'h12); wr(4'h7, 8'h34);
    chk_outs("R4 pointer cleared");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule